// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, A and B, through a set of identical bit channels. Each direction owns a storage register with its own capture clock: the A-to-B clock samples bus A, the B-to-A clock samples bus B. On its way to the far bus, each direction forwards either the live value from the near bus or the value held in its register. The choice is made by a per-direction select input. A per-direction enable decides whether the far bus is driven at all.

Each bus is presented as an input, an output and an output-enable. This keeps the logic synthesizable; the pad ring or the bench resolves the wires. When both directions run live and both are enabled, each bus drives the other through the block. With every other driver released, the pair then holds its last value. The output multiplexer carries a consensus term, so changing a select while the register and the live value agree leaves the output steady.

The reset input is asynchronous and active low. Its release is synchronised separately into each capture clock domain.

Top module: `regx_xcvr`

## Requirements
- R1: The data path is WIDTH bits wide (default 8), built from identical channels; every bit position is carried independently of the others.
- R2: A rising edge of clk_ab loads a_in into the A register. A rising edge of clk_ba loads b_in into the B register.
- R3: Capture takes place on those edges whatever the levels of sel_ab, sel_ba, en_ab and en_ba_n, including while the captured direction is driving its bus.
- R4: With sel_ab = 0, b_out equals a_in (live); with sel_ab = 1, b_out equals the A register (stored). sel_ba picks between b_in and the B register for a_out in the same way.
- R5: While rst_n is high, b_oe equals en_ab (active high) and a_oe equals the inverse of en_ba_n (active low).
- R6: With sel_ab = 0, sel_ba = 0, en_ab = 1 and en_ba_n = 0, a_out equals b_in and b_out equals a_in. Once every external driver releases, both resolved buses keep their last value.
- R7: When a channel's register bit equals its live bit, the driven bit equals that value for either select level and across select changes.
- R8: rst_n low clears both registers at once without a clock edge. While it is low, a_oe and b_oe are both 0.
- R9: After rst_n rises, the first two rising edges of each capture clock capture nothing; the third edge captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ab | input | 1 | Capture clock for the A register (samples bus A) |
| clk_ba | input | 1 | Capture clock for the B register (samples bus B) |
| sel_ab | input | 1 | Source toward B: 0 live A, 1 stored A register |
| sel_ba | input | 1 | Source toward A: 0 live B, 1 stored B register |
| en_ab | input | 1 | Drive enable toward B, active high |
| en_ba_n | input | 1 | Drive enable toward A, active low |
| a_in | input | WIDTH | Resolved value of bus A |
| a_out | output | WIDTH | Value driven onto bus A |
| a_oe | output | 1 | Output enable for bus A |
| b_in | input | WIDTH | Resolved value of bus B |
| b_out | output | WIDTH | Value driven onto bus B |
| b_oe | output | 1 | Output enable for bus B |

## Verification
The bench targets several corner cases:

- **Reset release.** It counts capture edges after rst_n rises. A design that skipped the synchroniser would capture on the first edge; one with an extra stage would miss the third.
- **Capture while driving.** It captures while a direction is already driving in stored mode. Gating capture with the enable or the select would leave the old value on the bus.
- **Bus hold.** It sets up the hold configuration, then releases the external driver. A design that swapped a select polarity or forgot a term would let the buses drop to the undriven value.
- **Select toggling and clearing.** It toggles a select while stored and live values agree, and checks that a clear needs no clock. The clear must also force both enables low even while both directions request driving.

// File: rtl/regx_pkg.sv
`timescale 1ns/1ps
package regx_pkg;

  localparam int DEFAULT_WIDTH = 8;
  localparam int DEFAULT_SYNC_STAGES = 2;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

endpackage

// File: rtl/regx_rst_sync.sv
`timescale 1ns/1ps
module regx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam logic [STAGES-1:0] SHIFT_IN = STAGES'(1);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = (chain_q << 1) | SHIFT_IN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/regx_capture.sv
`timescale 1ns/1ps
module regx_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;
  logic             load_en;

  // capture on every edge regardless of select or enable
  assign load_en = 1'b1;

  always_comb begin
    hold_d = hold_q;
    if (load_en) begin
      hold_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign q_o = hold_q;

  // R2 R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q_o == $past(d_i)));

endmodule

// File: rtl/regx_mux_cell.sv
`timescale 1ns/1ps
module regx_mux_cell
  import regx_pkg::*;
(
  input  logic live_i,
  input  logic stored_i,
  input  logic sel_i,
  output logic out_o
);

  src_sel_e src;
  logic     pick_stored;

  assign src = src_sel_e'(sel_i);
  assign pick_stored = (src == SRC_STORED);

  // consensus term keeps the output steady when both sources agree
  always_comb begin
    out_o = (live_i & ~pick_stored) | (stored_i & pick_stored) | (live_i & stored_i);
  end

endmodule

// File: rtl/regx_direction.sv
`timescale 1ns/1ps
module regx_direction #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data_i,
  input  logic             sel_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] drv_o,
  output logic             oe_o
);

  logic             dom_rst_n;
  logic [WIDTH-1:0] stored;

  regx_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (dom_rst_n)
  );

  regx_capture #(.WIDTH(WIDTH)) u_cap (
    .clk   (clk),
    .rst_n (dom_rst_n),
    .d_i   (data_i),
    .q_o   (stored)
  );

  for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
    regx_mux_cell u_mux (
      .live_i   (data_i[ch]),
      .stored_i (stored[ch]),
      .sel_i    (sel_i),
      .out_o    (drv_o[ch])
    );
  end

  assign oe_o = rst_n & en_i;

  // R7
  always_comb begin
    consensus_chk: assert (((drv_o ^ data_i) & ~(data_i ^ stored)) == '0);
  end

endmodule

// File: rtl/regx_xcvr.sv
`timescale 1ns/1ps
module regx_xcvr
  import regx_pkg::*;
#(
  parameter int WIDTH       = DEFAULT_WIDTH,
  parameter int SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             en_ab,
  input  logic             en_ba_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  logic drive_a_req;
  logic hold_cfg;

  assign drive_a_req = ~en_ba_n;
  assign hold_cfg = rst_n & ~sel_ab & ~sel_ba & en_ab & drive_a_req;

  regx_direction #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_ab (
    .clk    (clk_ab),
    .rst_n  (rst_n),
    .data_i (a_in),
    .sel_i  (sel_ab),
    .en_i   (en_ab),
    .drv_o  (b_out),
    .oe_o   (b_oe)
  );

  regx_direction #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_ba (
    .clk    (clk_ba),
    .rst_n  (rst_n),
    .data_i (b_in),
    .sel_i  (sel_ba),
    .en_i   (drive_a_req),
    .drv_o  (a_out),
    .oe_o   (a_oe)
  );

  // R8
  always_comb begin
    if (!rst_n) begin
      oe_reset_chk: assert (!a_oe && !b_oe);
    end
  end

  // R6
  always_comb begin
    if (hold_cfg) begin
      hold_chk: assert ((a_out == b_in) && (b_out == a_in) && a_oe && b_oe);
    end
  end

endmodule

// File: tb/tb_regx_xcvr.sv
`timescale 1ns/1ps
module tb_regx_xcvr;

  localparam int W = 8;
  localparam int NVEC = 6;
  localparam int WATCHDOG = 20000;
  // each entry: {A pattern, B pattern}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h00FF, 16'hFF00, 16'hA55A, 16'h0180, 16'h7E81, 16'h3CC3
  };

  logic clk = 1'b0;
  logic rst_n, clk_ab, clk_ba, sel_ab, sel_ba, en_ab, en_ba_n;
  logic [W-1:0] a_out, b_out, ext_a, ext_b;
  logic a_oe, b_oe, ext_a_en, ext_b_en;
  wire  [W-1:0] bus_a;
  wire  [W-1:0] bus_b;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  assign bus_a = a_oe ? a_out : 8'bz;
  assign bus_a = ext_a_en ? ext_a : 8'bz;
  assign bus_b = b_oe ? b_out : 8'bz;
  assign bus_b = ext_b_en ? ext_b : 8'bz;

  regx_xcvr dut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .a_in(bus_a), .a_out(a_out), .a_oe(a_oe),
    .b_in(bus_b), .b_out(b_out), .b_oe(b_oe)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_ab();
    #2; clk_ab = 1'b1; #5; clk_ab = 1'b0; #3;
  endtask

  task automatic pulse_ba();
    #2; clk_ba = 1'b1; #5; clk_ba = 1'b0; #3;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0;
    sel_ab = 1'b1; sel_ba = 1'b1; en_ab = 1'b1; en_ba_n = 1'b0;
    ext_a = '0; ext_b = '0; ext_a_en = 1'b0; ext_b_en = 1'b0;
    #7;
    // R8: enables requested but held off in reset
    check("R8 a_oe in reset", {7'b0, a_oe}, 8'h00);
    check("R8 b_oe in reset", {7'b0, b_oe}, 8'h00);
    en_ab = 1'b0; en_ba_n = 1'b1;
    #3; rst_n = 1'b1; #3;

    // R9: two edges after release do not capture
    ext_a = 8'h5A; ext_a_en = 1'b1; ext_b = 8'hA5; ext_b_en = 1'b1;
    pulse_ab(); pulse_ab(); pulse_ba(); pulse_ba();
    ext_b_en = 1'b0; en_ab = 1'b1; sel_ab = 1'b1; #2;
    check("R9 A reg after two edges", bus_b, 8'h00);
    en_ab = 1'b0; ext_b_en = 1'b1; ext_a_en = 1'b0; en_ba_n = 1'b0; sel_ba = 1'b1; #2;
    check("R9 B reg after two edges", bus_a, 8'h00);
    en_ba_n = 1'b1; ext_a_en = 1'b1; #2;
    pulse_ab(); pulse_ba();
    ext_b_en = 1'b0; en_ab = 1'b1; #2;
    check("R9 A reg third edge", bus_b, 8'h5A);
    en_ab = 1'b0; ext_b_en = 1'b1; ext_a_en = 1'b0; en_ba_n = 1'b0; #2;
    check("R9 B reg third edge", bus_a, 8'hA5);
    en_ba_n = 1'b1; ext_a_en = 1'b1; #2;

    // R1 R2 R4 R5: vector walk
    for (int i = 0; i < NVEC; i++) begin
      logic [W-1:0] av, bv;
      av = VEC[i][15:8]; bv = VEC[i][7:0];
      ext_a = av; ext_b = bv; ext_a_en = 1'b1; ext_b_en = 1'b1; #2;
      pulse_ab(); pulse_ba();
      ext_a = ~av; ext_b = ~bv;
      ext_b_en = 1'b0; en_ab = 1'b1; sel_ab = 1'b1; #2;
      check("R2 R4 stored toward B", bus_b, av);
      check("R5 b_oe on", {7'b0, b_oe}, 8'h01);
      sel_ab = 1'b0; #2;
      check("R1 R4 live toward B", bus_b, ~av);
      en_ab = 1'b0; ext_b_en = 1'b1; ext_a_en = 1'b0; en_ba_n = 1'b0; sel_ba = 1'b1; #2;
      check("R2 R4 stored toward A", bus_a, bv);
      sel_ba = 1'b0; #2;
      check("R1 R4 live toward A", bus_a, ~bv);
      en_ba_n = 1'b1; ext_a_en = 1'b1; #2;
      check("R5 a_oe off", {7'b0, a_oe}, 8'h00);
    end

    // R3: capture while driving in stored mode
    ext_b_en = 1'b0; en_ab = 1'b1; sel_ab = 1'b1; ext_a = 8'h3C; #2;
    pulse_ab();
    check("R3 capture while driving", bus_b, 8'h3C);
    // R3: capture with enable off and live select
    en_ab = 1'b0; sel_ab = 1'b0; ext_b_en = 1'b1; ext_a = 8'hC3; #2;
    pulse_ab();
    ext_b_en = 1'b0; en_ab = 1'b1; sel_ab = 1'b1; ext_a = 8'h00; #2;
    check("R3 capture while disabled", bus_b, 8'hC3);
    en_ab = 1'b0; #2;
    check("R5 b_oe off", {7'b0, b_oe}, 8'h00);

    // R7: toggle select with equal live and stored values
    ext_a = 8'hC3; en_ab = 1'b1; #2;
    for (int k = 0; k < 4; k++) begin
      sel_ab = ~sel_ab; #1;
      check("R7 steady across select", bus_b, 8'hC3);
    end

    // R6: bus hold
    en_ab = 1'b0; en_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
    ext_a = 8'h96; ext_a_en = 1'b1; ext_b_en = 1'b0; #2;
    en_ab = 1'b1; #2; en_ba_n = 1'b0; #2;
    ext_a_en = 1'b0; #10;
    check("R6 hold bus A", bus_a, 8'h96);
    check("R6 hold bus B", bus_b, 8'h96);
    en_ab = 1'b0; #2; en_ba_n = 1'b1; #2;

    // R8: asynchronous clear without any clock edge
    sel_ab = 1'b1; sel_ba = 1'b1; en_ab = 1'b1; en_ba_n = 1'b0;
    rst_n = 1'b0; #3;
    check("R8 a_oe clear", {7'b0, a_oe}, 8'h00);
    check("R8 b_oe clear", {7'b0, b_oe}, 8'h00);
    rst_n = 1'b1; #2;
    check("R8 A reg cleared", bus_b, 8'h00);
    check("R8 B reg cleared", bus_a, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule